// File: doc/BRIEF.md
# Dithered Pulse Synthesizer with Frequency Modulation

The block divides its system clock by a fractional ratio and emits a one-bit, roughly square pulse train. An N-bit phase register grows by an effective step every enabled cycle. The top bit of the (optionally dithered) phase is the output, so its average frequency is step · f_clk / 2^N. The step is built from a tuning word one bit narrower than the phase register, plus a signed modulation sample, so the carrier is frequency modulated sample by sample.

A pseudo-random sequence from a shift register can be mixed in to break up the periodic edge-timing error that causes spurs. It can go into the step (frequency dither), or be added only to the value the output bit is taken from, leaving the phase register itself clean (phase dither). A two-bit mode input selects the dither, and a new mode is registered before it acts.

Top module: `pdds_fm_mod`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the phase register, loads the shift register with the seed `SEED`, selects no dither, and makes `pulse_out` 0.
- R2: On each clock edge with `en` high, the phase register adds the effective step modulo 2^PHASE_W. `pulse_out` is bit PHASE_W-1 of the phase value after any phase dither. It changes only right after a clock edge.
- R3: The effective step is `fcw` plus the sign-extended `mod_sample` plus any frequency dither, clamped to 0 when the sum is negative and to 2^(PHASE_W-1)-1 when it exceeds that value.
- R4: The signed modulation sample is added to the tuning word afresh in every cycle, so a changing `mod_sample` changes the phase increment cycle by cycle.
- R5: The dither source is a shift register of LFSR_W bits that shifts left by one on every enabled cycle. The new bit 0 is the XOR of bits 15, 13, 12 and 10 for LFSR_W = 16. The dither value is its low DITH_W bits, sign-extended (DITH_SIGNED = 1) to the phase width.
- R6: With the registered mode equal to 2'b01 (frequency dither), the dither value is added to the step before saturation.
- R7: With the registered mode equal to 2'b10 (phase dither), the dither value is added to the phase register's value to form the output phase. The phase register itself is never dithered, so output after returning to mode 2'b00 matches an undithered accumulation.
- R8: Modes 2'b00 and 2'b11 apply no dither. A value on `dither_mode` first acts after the clock edge that samples it.
- R9: While `en` is low, the phase register and the shift register hold their values, so `pulse_out` does not change.
- R10: With no dither and a constant step w, `pulse_out` makes exactly w rising transitions in 2^PHASE_W enabled cycles starting from reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the phase and dither source when high |
| fcw | input | PHASE_W-1 | Unsigned tuning word |
| mod_sample | input | MOD_W | Signed modulation sample added to the tuning word |
| dither_mode | input | 2 | 00/11 none, 01 frequency dither, 10 phase dither |
| pulse_out | output | 1 | One-bit synthesized output |

## Verification
The bench builds the block with a 12-bit phase, an 8-bit modulation sample, 4-bit signed dither and the 16-bit shift register. The narrow phase wraps fully in 4096 cycles, so the exact transition count of R10 can be checked in a short run. The 8-bit sample reaches both saturation limits from ordinary tuning words. The small dither width keeps phase-dithered edges near their clean positions, so a wrong sign or extension shows up as output mismatches rather than noise.

// File: rtl/pdds_pkg.sv
package pdds_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    DM_NONE     = 2'b00,
    DM_FREQ     = 2'b01,
    DM_PHASE    = 2'b10,
    DM_NONE_ALT = 2'b11
  } dith_mode_e;

  // Feedback tap mask for a left-shifting maximal-length register.
  function automatic logic [31:0] lfsr_taps(input int width);
    case (width)
      8:       return 32'h0000_00B8;
      24:      return 32'h00E1_0000;
      32:      return 32'h8020_0003;
      default: return 32'h0000_B400;
    endcase
  endfunction
endpackage

// File: rtl/pdds_lfsr.sv
module pdds_lfsr #(
  parameter int                LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED   = LFSR_W'('hACE1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [LFSR_W-1:0] state_q
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [31:0]       TAP_ALL = pdds_pkg::lfsr_taps(LFSR_W);
  localparam logic [LFSR_W-1:0] TAPS    = TAP_ALL[LFSR_W-1:0];

  logic fb;
  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk) begin
    if (rst)      state_q <= SEED;
    else if (adv) state_q <= {state_q[LFSR_W-2:0], fb};
  end
endmodule

// File: rtl/pdds_dither_ext.sv
module pdds_dither_ext #(
  parameter int PHASE_W     = 24,
  parameter int DITH_W      = 6,
  parameter bit DITH_SIGNED = 1'b1
) (
  input  logic [DITH_W-1:0]  raw,
  output logic [PHASE_W-1:0] dith
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PAD_W = PHASE_W - DITH_W;

  generate
    if (DITH_SIGNED) begin : g_sext
      assign dith = {{PAD_W{raw[DITH_W-1]}}, raw};
    end else begin : g_zext
      assign dith = {{PAD_W{1'b0}}, raw};
    end
  endgenerate
endmodule

// File: rtl/pdds_step_calc.sv
module pdds_step_calc #(
  parameter int PHASE_W = 24,
  parameter int MOD_W   = 16
) (
  input  logic [PHASE_W-2:0]      fcw,
  input  logic signed [MOD_W-1:0] mod_sample,
  input  logic [PHASE_W-1:0]      dith,
  input  logic                    use_dith,
  output logic [PHASE_W-2:0]      step
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SUM_W = ((PHASE_W > MOD_W) ? PHASE_W : MOD_W) + 2;
  localparam logic signed [SUM_W-1:0] STEP_MAX =
    SUM_W'((64'd1 << (PHASE_W - 1)) - 64'd1);

  function automatic logic [PHASE_W-2:0] clamp_step(input logic signed [SUM_W-1:0] s);
    if (s < 0)             return '0;
    else if (s > STEP_MAX) return '1;
    else                   return s[PHASE_W-2:0];
  endfunction

  logic signed [SUM_W-1:0] fcw_s, mod_s, dith_s, sum_s;

  always_comb begin
    fcw_s  = SUM_W'(fcw);
    mod_s  = SUM_W'(mod_sample);
    dith_s = use_dith ? SUM_W'(signed'(dith)) : '0;
    sum_s  = fcw_s + mod_s + dith_s;
    step   = clamp_step(sum_s);
  end
endmodule

// File: rtl/pdds_phase_acc.sv
module pdds_phase_acc #(
  parameter int PHASE_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic [PHASE_W-2:0] step,
  output logic [PHASE_W-1:0] acc_q
);
  timeunit 1ns;
  timeprecision 1ps;

  always_ff @(posedge clk) begin
    if (rst)      acc_q <= '0;
    else if (adv) acc_q <= acc_q + PHASE_W'(step);
  end
endmodule

// File: rtl/pdds_fm_mod.sv
module pdds_fm_mod #(
  parameter int                PHASE_W     = 24,
  parameter int                MOD_W       = 16,
  parameter int                DITH_W      = 6,
  parameter int                LFSR_W      = 16,
  parameter bit                DITH_SIGNED = 1'b1,
  parameter logic [LFSR_W-1:0] SEED        = LFSR_W'('hACE1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [PHASE_W-2:0]      fcw,
  input  logic signed [MOD_W-1:0] mod_sample,
  input  logic [1:0]              dither_mode,
  output logic                    pulse_out
);
  timeunit 1ns;
  timeprecision 1ps;
  import pdds_pkg::*;

  localparam int FCW_W = PHASE_W - 1;

  dith_mode_e         mode_q;
  logic [LFSR_W-1:0]  lfsr_q;
  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] dith_w;
  logic [FCW_W-1:0]   step_w;
  logic [PHASE_W-1:0] phase_w;
  logic               freq_dith_on;
  logic               phase_dith_on;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= DM_NONE;
    else     mode_q <= dith_mode_e'(dither_mode);
  end

  assign freq_dith_on  = (mode_q == DM_FREQ);
  assign phase_dith_on = (mode_q == DM_PHASE);

  pdds_lfsr #(.LFSR_W(LFSR_W), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .adv(en), .state_q(lfsr_q)
  );

  pdds_dither_ext #(.PHASE_W(PHASE_W), .DITH_W(DITH_W), .DITH_SIGNED(DITH_SIGNED)) u_dext (
    .raw(lfsr_q[DITH_W-1:0]), .dith(dith_w)
  );

  pdds_step_calc #(.PHASE_W(PHASE_W), .MOD_W(MOD_W)) u_step (
    .fcw(fcw), .mod_sample(mod_sample), .dith(dith_w),
    .use_dith(freq_dith_on), .step(step_w)
  );

  pdds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst(rst), .adv(en), .step(step_w), .acc_q(acc_q)
  );

  assign phase_w   = acc_q + (phase_dith_on ? dith_w : '0);
  assign pulse_out = phase_w[PHASE_W-1];
endmodule

// File: rtl/pdds_fm_mod_chk.sv
module pdds_fm_mod_chk #(
  parameter int                PHASE_W = 24,
  parameter int                MOD_W   = 16,
  parameter int                LFSR_W  = 16,
  parameter logic [LFSR_W-1:0] SEED    = LFSR_W'('hACE1)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic [PHASE_W-2:0]      fcw,
  input logic signed [MOD_W-1:0] mod_sample,
  input logic [1:0]              dither_mode,
  input logic                    pulse_out,
  input logic [PHASE_W-1:0]      acc_q,
  input logic [LFSR_W-1:0]       lfsr_q,
  input logic [1:0]              mode_q,
  input logic [PHASE_W-2:0]      step_w,
  input logic [PHASE_W-1:0]      phase_w
);
  timeunit 1ns;
  timeprecision 1ps;

  logic signed [63:0] raw_sum;
  assign raw_sum = $signed({32'd0, 32'(fcw)}) + 64'(mod_sample);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (acc_q == '0) && (lfsr_q == SEED) && (mode_q == 2'b00) && !pulse_out);

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc_q) && $stable(lfsr_q) && $stable(pulse_out));

  a_r5_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);

  a_r7_clean_phase: assert property (@(posedge clk) disable iff (rst)
    (mode_q != 2'b10) |-> (phase_w == acc_q));

  a_r8_mode_latency: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mode_q == $past(dither_mode)));

  a_r3_sat_top: assert property (@(posedge clk) disable iff (rst)
    (mode_q != 2'b01 && fcw == '1 && mod_sample > 0) |-> (step_w == '1));

  a_r3_sat_bottom: assert property (@(posedge clk) disable iff (rst)
    (mode_q != 2'b01 && raw_sum < 0) |-> (step_w == '0));

  a_r4_zero_mod_step: assert property (@(posedge clk) disable iff (rst)
    (mode_q != 2'b01 && mod_sample == '0) |-> (step_w == fcw));

  a_r2_msb_output: assert property (@(posedge clk) disable iff (rst)
    (mode_q != 2'b10) |-> (pulse_out == acc_q[PHASE_W-1]));
endmodule

bind pdds_fm_mod pdds_fm_mod_chk #(
  .PHASE_W(PHASE_W), .MOD_W(MOD_W), .LFSR_W(LFSR_W), .SEED(SEED)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .fcw(fcw), .mod_sample(mod_sample),
  .dither_mode(dither_mode), .pulse_out(pulse_out), .acc_q(acc_q),
  .lfsr_q(lfsr_q), .mode_q(mode_q), .step_w(step_w), .phase_w(phase_w)
);

// File: tb/pdds_fm_mod_tb.sv
module pdds_fm_mod_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PW = 12;
  localparam int MW = 8;
  localparam int DW = 4;
  localparam int PMASK = (1 << PW) - 1;
  localparam int SMAX  = (1 << (PW - 1)) - 1;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               en  = 1'b0;
  logic [PW-2:0]      fcw = '0;
  logic signed [MW-1:0] mod_sample = '0;
  logic [1:0]         dither_mode = 2'b00;
  logic               pulse_out;

  always #4 clk = ~clk;

  pdds_fm_mod #(.PHASE_W(PW), .MOD_W(MW), .DITH_W(DW), .LFSR_W(16),
                .DITH_SIGNED(1'b1), .SEED(16'hACE1)) u_dut (
    .clk(clk), .rst(rst), .en(en), .fcw(fcw), .mod_sample(mod_sample),
    .dither_mode(dither_mode), .pulse_out(pulse_out)
  );

  typedef struct { bit exp; string tag; } sb_item_t;
  sb_item_t sb[$];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int m_acc, m_lfsr, m_mode;

  function automatic int dith_of(input int s);
    int d = s % 16;
    if (d >= 8) d = d - 16;
    return d;
  endfunction

  function automatic int lfsr_step(input int s);
    int fb = ((s >> 15) ^ (s >> 13) ^ (s >> 12) ^ (s >> 10)) & 1;
    return ((s << 1) | fb) & 16'hFFFF;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the expected output.
  task automatic drive(input int f, input int m, input int md, input bit e, input string tag);
    int st;
    sb_item_t it;
    fcw         <= (PW-1)'(f);
    mod_sample  <= MW'(m);
    dither_mode <= 2'(md);
    en          <= e;
    st = f + m + ((m_mode == 1) ? dith_of(m_lfsr) : 0);
    if (st < 0) st = 0;
    if (st > SMAX) st = SMAX;
    if (e) begin
      m_acc  = (m_acc + st) & PMASK;
      m_lfsr = lfsr_step(m_lfsr);
    end
    m_mode = md;
    it.exp = bit'((((m_acc + ((m_mode == 2) ? dith_of(m_lfsr) : 0)) & PMASK) >> (PW - 1)) & 1);
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: compare the design output between edges.
  always @(posedge clk) begin
    #2;
    if (sb.size() != 0) begin
      sb_item_t it;
      it = sb.pop_front();
      check(pulse_out === it.exp, it.tag, int'(pulse_out), int'(it.exp));
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst <= 1'b1; en <= 1'b0; dither_mode <= 2'b00;
    repeat (3) @(negedge clk);
    rst <= 1'b0;
    m_acc = 0; m_lfsr = 16'hACE1; m_mode = 0;
    #1;
    check(pulse_out === 1'b0, "R1 reset output", int'(pulse_out), 0);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int rises;
    bit prev;
    do_reset();

    // R2 / R10: clean accumulation, exact transition count over one full wrap
    rises = 0; prev = 1'b0;
    for (int i = 0; i < (1 << PW); i++) begin
      drive(100, 0, 0, 1'b1, "R2 clean accumulate");
      if (pulse_out && !prev) rises++;
      prev = pulse_out;
    end
    check(rises == 100, "R10 rising transitions", rises, 100);

    // R4: cycle-by-cycle frequency modulation
    for (int i = 0; i < 300; i++) drive(1000, ((i * 37) % 256) - 128, 0, 1'b1, "R4 fm sample");

    // R3: clamp at the top and at zero
    for (int i = 0; i < 60; i++) drive(2040, 127, 0, 1'b1, "R3 clamp high");
    for (int i = 0; i < 60; i++) drive(5, -128, 0, 1'b1, "R3 clamp low");

    // R6 / R5: frequency dither
    for (int i = 0; i < 400; i++) drive(700, 0, 1, 1'b1, "R6 freq dither");
    for (int i = 0; i < 200; i++) drive(2045, 3, 1, 1'b1, "R6 freq dither near top");

    // R7 / R5: phase dither, then back to clean
    for (int i = 0; i < 300; i++) drive(333, 0, 2, 1'b1, "R7 phase dither");
    for (int i = 0; i < 100; i++) drive(333, 0, 0, 1'b1, "R7 clean after phase dither");

    // R8: mode 11 and rapid mode switching
    for (int i = 0; i < 200; i++) drive(900, 20, 3, 1'b1, "R8 mode 11 no dither");
    for (int i = 0; i < 150; i++) drive(611, -7, i % 4, 1'b1, "R8 mode switching");

    // R9: enable gaps in both dither modes
    for (int i = 0; i < 200; i++) drive(450, 0, 2, (i % 5) != 0, "R9 hold phase mode");
    for (int i = 0; i < 200; i++) drive(450, 11, 1, (i % 3) != 0, "R9 hold freq mode");

    // R1: reset mid-run, then clean run from seed
    do_reset();
    for (int i = 0; i < 100; i++) drive(1500, 0, 2, 1'b1, "R1 after reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule